// File: doc/BRIEF.md
# Privileged Stack Pointer Fetch Sequencer

When a call raises the privilege level, the processor must move to the stack that belongs to the target level. This block works out where that stack lives. It takes the current task state segment's base address, limit, format and selector, along with the target privilege level and the long-mode flag. From these it finds the stack slot for that level, checks that the slot fits inside the segment, and fetches the stack pointer and stack selector through a simple read port. It then returns either the new stack selector and pointer or a task-segment fault with its error code.

The slot position, the bytes past the slot start that must lie inside the limit, and the read widths all depend on the segment format. A 64-bit segment holds no stack selector. For that format the block makes a null selector whose requested-privilege bits equal the target level. Outside long mode, a fetched selector that is null is reported as a fault. The block accepts one request at a time, has at most one read outstanding, and marks the end of each sequence with a one-cycle done pulse.

Top module: `stack_slot_fetch`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. While idle, no memory request is raised.
- R2: For format code 01 (32-bit segment), the slot offset is level×8+4. The pointer is read as 4 bytes (`mem_size`=2) at base+offset and zero-extended to 64 bits. The selector is then read as 2 bytes (`mem_size`=1) at base+offset+4. Addresses wrap at the address width.
- R3: For format code 00 (16-bit segment), the slot offset is level×4+2. The pointer is read as 2 bytes (`mem_size`=1) at base+offset and zero-extended. The selector is read as 2 bytes at base+offset+2.
- R4: For format codes 10 and 11 (64-bit segment), the slot offset is level×8+4. A single 8-byte read (`mem_size`=3) at base+offset supplies the full pointer, and no selector read follows. `new_ss` has bits 1:0 equal to the level and all other bits zero.
- R5: A request faults when offset plus a margin is greater than `tss_limit`. The margin is 3 for format 00, 5 for format 01 and 7 for formats 1x. On such a fault `fault_code` equals `tss_sel`, and no memory read is issued for that request.
- R6: When `long_mode` is low and the fetched selector has bits 15:2 all zero, the request ends in a fault whose `fault_code` is the fetched selector. When `long_mode` is high, no such check is made.
- R7: The pointer read comes before the selector read, and only one read is outstanding at a time. A raised request keeps its address and size unchanged until `mem_req_ready` is seen. No new request is raised while waiting for `mem_rsp_valid`.
- R8: `done` is a one-cycle pulse. It appears the cycle after the last response, or the cycle after acceptance when the limit check fails. `fault`, `fault_code`, `new_ss` and `new_sp` are valid with `done` and hold their values until the next request is accepted.
- R9: After reset, `req_ready` is 1, and `mem_req_valid`, `done`, `fault`, `new_ss` and `new_sp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| tss_base | input | AW | Base address of the current task state segment |
| tss_limit | input | LIMW | Byte limit of the current task state segment |
| tss_fmt | input | 2 | Segment format: 00 16-bit, 01 32-bit, 1x 64-bit |
| tss_sel | input | SELW | Selector of the current task state segment |
| new_dpl | input | 2 | Privilege level of the target code segment |
| long_mode | input | 1 | Long mode active |
| mem_req_valid | output | 1 | Read request raised |
| mem_req_ready | input | 1 | Read request taken by memory |
| mem_addr | output | AW | Read byte address |
| mem_size | output | 2 | Read size as log2 of bytes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data, least significant byte at the request address |
| done | output | 1 | Sequence finished, outputs valid |
| fault | output | 1 | Sequence ended in a task-segment fault |
| fault_code | output | SELW | Error code of the fault |
| new_ss | output | SELW | New stack selector |
| new_sp | output | 64 | New stack pointer |

## Verification
The hardest cases to reach are the ones where the limit and the slot sit exactly on the fault boundary, and where a fetched selector is null but has non-zero requested-privilege bits. Random limits almost never land on these points. The stimulus therefore picks each limit as the computed slot end plus a small signed jitter, so accepted and rejected slots each occur about half the time. Directed cases pin the exact boundary for every format and level. The bench memory model also forces selector responses with bits 15:2 clear, in both long and non-long mode. It adds random delays on request acceptance and on the response, to test that the address is held and that only one read is outstanding.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

  localparam int SP_W   = 64;
  localparam int OFF_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SP_REQ  = 3'd1,
    ST_SP_WAIT = 3'd2,
    ST_SS_REQ  = 3'd3,
    ST_SS_WAIT = 3'd4,
    ST_FINISH  = 3'd5
  } seq_state_e;

  // format 1x: 64-bit segment, no selector in the slot
  function automatic logic fmt_is_wide(input logic [1:0] fmt);
    return fmt[1];
  endfunction

  // slot offset built from bit fields: level*4+2 or level*8+4
  function automatic logic [OFF_W-1:0] slot_offset(input logic [1:0] fmt,
                                                   input logic [1:0] dpl);
    logic [OFF_W-1:0] r;
    if (fmt == 2'b00) r = {4'b0000, dpl, 2'b10};
    else              r = {3'b000, dpl, 3'b100};
    return r;
  endfunction

  // bytes past the slot start that must lie inside the limit
  function automatic logic [3:0] slot_margin(input logic [1:0] fmt);
    logic [3:0] r;
    case (fmt)
      2'b00:   r = 4'd3;
      2'b01:   r = 4'd5;
      default: r = 4'd7;
    endcase
    return r;
  endfunction

  // distance from the pointer field to the selector field
  function automatic logic [OFF_W-1:0] ss_displacement(input logic [1:0] fmt);
    return (fmt == 2'b00) ? OFF_W'(2) : OFF_W'(4);
  endfunction

  // log2 of the pointer read width in bytes
  function automatic logic [1:0] sp_size(input logic [1:0] fmt);
    logic [1:0] r;
    case (fmt)
      2'b00:   r = 2'd1;
      2'b01:   r = 2'd2;
      default: r = 2'd3;
    endcase
    return r;
  endfunction

  function automatic logic [SP_W-1:0] sp_extend(input logic [1:0] fmt,
                                                input logic [SP_W-1:0] d);
    logic [SP_W-1:0] r;
    case (fmt)
      2'b00:   r = {48'd0, d[15:0]};
      2'b01:   r = {32'd0, d[31:0]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ssf_slot_calc.sv
module ssf_slot_calc
  import ssf_pkg::*;
#(
  parameter int LIMW = 32
) (
  input  logic [1:0]       fmt,
  input  logic [1:0]       dpl,
  input  logic [LIMW-1:0]  limit,
  output logic [OFF_W-1:0] sp_off,
  output logic [OFF_W-1:0] ss_off,
  output logic             over_limit
);

  localparam int REACH_W = LIMW + 1;

  logic [REACH_W-1:0] reach;

  always_comb begin
    sp_off     = slot_offset(fmt, dpl);
    ss_off     = sp_off + ss_displacement(fmt);
    reach      = REACH_W'(sp_off) + REACH_W'(slot_margin(fmt));
    over_limit = reach > {1'b0, limit};
  end

endmodule

// File: rtl/ssf_seq.sv
module ssf_seq
  import ssf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_fault,
  input  logic [1:0]       fmt_in,
  input  logic [AW-1:0]    base_in,
  input  logic [OFF_W-1:0] sp_off_in,
  input  logic [OFF_W-1:0] ss_off_in,
  output logic             idle,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_addr,
  output logic [1:0]       mem_size,
  input  logic             mem_rsp_valid,
  output logic             sp_cap,
  output logic             ss_cap,
  output logic             done,
  output logic [1:0]       fmt_q
);

  seq_state_e       state, state_nx;
  logic [AW-1:0]    base_q;
  logic [OFF_W-1:0] sp_off_q;
  logic [OFF_W-1:0] ss_off_q;
  logic             on_ss;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (start) state_nx = start_fault ? ST_FINISH : ST_SP_REQ;
      ST_SP_REQ:  if (mem_req_ready) state_nx = ST_SP_WAIT;
      ST_SP_WAIT: if (mem_rsp_valid) state_nx = fmt_is_wide(fmt_q) ? ST_FINISH : ST_SS_REQ;
      ST_SS_REQ:  if (mem_req_ready) state_nx = ST_SS_WAIT;
      ST_SS_WAIT: if (mem_rsp_valid) state_nx = ST_FINISH;
      ST_FINISH:  state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      base_q   <= '0;
      sp_off_q <= '0;
      ss_off_q <= '0;
      fmt_q    <= 2'b00;
    end else begin
      state <= state_nx;
      if (start && state == ST_IDLE) begin
        base_q   <= base_in;
        sp_off_q <= sp_off_in;
        ss_off_q <= ss_off_in;
        fmt_q    <= fmt_in;
      end
    end
  end

  always_comb begin
    idle          = state == ST_IDLE;
    on_ss         = state == ST_SS_REQ;
    mem_req_valid = (state == ST_SP_REQ) || on_ss;
    mem_addr      = base_q + AW'(on_ss ? ss_off_q : sp_off_q);
    mem_size      = on_ss ? 2'd1 : sp_size(fmt_q);
    sp_cap        = (state == ST_SP_WAIT) && mem_rsp_valid;
    ss_cap        = (state == ST_SS_WAIT) && mem_rsp_valid;
    done          = state == ST_FINISH;
  end

endmodule

// File: rtl/ssf_result.sv
module ssf_result
  import ssf_pkg::*;
#(
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_fault,
  input  logic [1:0]      fmt_in,
  input  logic [1:0]      dpl_in,
  input  logic            long_in,
  input  logic [SELW-1:0] sel_in,
  input  logic            sp_cap,
  input  logic            ss_cap,
  input  logic [SP_W-1:0] rdata,
  output logic            null_hit,
  output logic [SP_W-1:0] new_sp,
  output logic [SELW-1:0] new_ss,
  output logic            fault,
  output logic [SELW-1:0] fault_code
);

  logic [1:0]      fmt_q;
  logic            long_q;
  logic [SELW-1:0] rd_sel;

  always_comb begin
    rd_sel   = rdata[SELW-1:0];
    null_hit = ss_cap && !long_q && (rd_sel[SELW-1:2] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q      <= 2'b00;
      long_q     <= 1'b0;
      new_sp     <= '0;
      new_ss     <= '0;
      fault      <= 1'b0;
      fault_code <= '0;
    end else if (start) begin
      fmt_q      <= fmt_in;
      long_q     <= long_in;
      new_sp     <= '0;
      new_ss     <= fmt_is_wide(fmt_in) ? {{(SELW-2){1'b0}}, dpl_in} : '0;
      fault      <= start_fault;
      fault_code <= start_fault ? sel_in : '0;
    end else begin
      if (sp_cap) new_sp <= sp_extend(fmt_q, rdata);
      if (ss_cap) begin
        new_ss <= rd_sel;
        if (null_hit) begin
          fault      <= 1'b1;
          fault_code <= rd_sel;
        end
      end
    end
  end

endmodule

// File: rtl/stack_slot_fetch.sv
module stack_slot_fetch
  import ssf_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LIMW = 32,
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   tss_base,
  input  logic [LIMW-1:0] tss_limit,
  input  logic [1:0]      tss_fmt,
  input  logic [SELW-1:0] tss_sel,
  input  logic [1:0]      new_dpl,
  input  logic            long_mode,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_size,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rdata,
  output logic            done,
  output logic            fault,
  output logic [SELW-1:0] fault_code,
  output logic [SELW-1:0] new_ss,
  output logic [63:0]     new_sp
);

  logic             accept;
  logic             limit_hit;
  logic             null_hit;
  logic             sp_cap;
  logic             ss_cap;
  logic [OFF_W-1:0] sp_off;
  logic [OFF_W-1:0] ss_off;
  logic [1:0]       fmt_q;

  assign accept = req_valid && req_ready;

  ssf_slot_calc #(.LIMW(LIMW)) u_calc (
    .fmt        (tss_fmt),
    .dpl        (new_dpl),
    .limit      (tss_limit),
    .sp_off     (sp_off),
    .ss_off     (ss_off),
    .over_limit (limit_hit)
  );

  ssf_seq #(.AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .start_fault   (limit_hit),
    .fmt_in        (tss_fmt),
    .base_in       (tss_base),
    .sp_off_in     (sp_off),
    .ss_off_in     (ss_off),
    .idle          (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_addr      (mem_addr),
    .mem_size      (mem_size),
    .mem_rsp_valid (mem_rsp_valid),
    .sp_cap        (sp_cap),
    .ss_cap        (ss_cap),
    .done          (done),
    .fmt_q         (fmt_q)
  );

  ssf_result #(.SELW(SELW)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_fault (limit_hit),
    .fmt_in      (tss_fmt),
    .dpl_in      (new_dpl),
    .long_in     (long_mode),
    .sel_in      (tss_sel),
    .sp_cap      (sp_cap),
    .ss_cap      (ss_cap),
    .rdata       (mem_rdata),
    .null_hit    (null_hit),
    .new_sp      (new_sp),
    .new_ss      (new_ss),
    .fault       (fault),
    .fault_code  (fault_code)
  );

endmodule

// File: rtl/ssf_checker.sv
module ssf_checker #(
  parameter int AW   = 32,
  parameter int SELW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            accept,
  input logic            limit_hit,
  input logic            null_hit,
  input logic [1:0]      fmt_q,
  input logic [SELW-1:0] tss_sel,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [AW-1:0]   mem_addr,
  input logic [1:0]      mem_size,
  input logic            done,
  input logic            fault,
  input logic [SELW-1:0] fault_code,
  input logic [SELW-1:0] new_ss
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) && $stable(mem_size));

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  a_r5_limit_fault: assert property (@(posedge clk) disable iff (!rst_n)
    accept && limit_hit |=> done && fault && fault_code == $past(tss_sel) && !mem_req_valid);

  a_r6_null_fault: assert property (@(posedge clk) disable iff (!rst_n)
    null_hit |=> done && fault);

  a_r4_wide_selector: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && fmt_q[1] |-> new_ss[SELW-1:2] == '0);

endmodule

bind stack_slot_fetch ssf_checker #(.AW(AW), .SELW(SELW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .accept        (accept),
  .limit_hit     (limit_hit),
  .null_hit      (null_hit),
  .fmt_q         (fmt_q),
  .tss_sel       (tss_sel),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_addr      (mem_addr),
  .mem_size      (mem_size),
  .done          (done),
  .fault         (fault),
  .fault_code    (fault_code),
  .new_ss        (new_ss)
);

// File: tb/sim_stack_slot_fetch.sv
module sim_stack_slot_fetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] tss_base = '0;
  logic [31:0] tss_limit = '0;
  logic [1:0]  tss_fmt = '0;
  logic [15:0] tss_sel = '0;
  logic [1:0]  new_dpl = '0;
  logic        long_mode = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done;
  logic        fault;
  logic [15:0] fault_code;
  logic [15:0] new_ss;
  logic [63:0] new_sp;

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  stack_slot_fetch u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .tss_base(tss_base), .tss_limit(tss_limit), .tss_fmt(tss_fmt), .tss_sel(tss_sel),
    .new_dpl(new_dpl), .long_mode(long_mode), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .fault_code(fault_code), .new_ss(new_ss), .new_sp(new_sp)
  );

  task automatic check_eq(input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic longint exp_off(input logic [1:0] f, input logic [1:0] l);
    longint lv = longint'(l);
    return (f == 2'b00) ? lv * 4 + 2 : lv * 8 + 4;
  endfunction

  function automatic longint exp_margin(input logic [1:0] f);
    return (f == 2'b00) ? 3 : ((f == 2'b01) ? 5 : 7);
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    return (f == 2'b00) ? "R3" : ((f == 2'b01) ? "R2" : "R4");
  endfunction

  // null_mode: 0 random selector, 1 selector with bits 15:2 clear
  task automatic run_txn(input logic [31:0] base, input logic [31:0] lim, input logic [1:0] f,
                         input logic [1:0] l, input logic lm, input logic [15:0] sel,
                         input int null_mode);
    longint off;
    bit     exp_fault;
    logic [63:0] d0;
    logic [63:0] d1;
    logic [63:0] sp_exp;
    logic [15:0] ss_exp;
    bit     is_null;
    @(negedge clk);
    check_eq("R1 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; tss_base = base; tss_limit = lim; tss_fmt = f;
    new_dpl = l; long_mode = lm; tss_sel = sel;
    @(negedge clk);
    req_valid = 1'b0;
    off = exp_off(f, l);
    exp_fault = (off + exp_margin(f)) > longint'(lim);
    d0 = '0; d1 = '0;
    if (exp_fault) begin
      check_eq("R5 no read on limit fault", 64'(mem_req_valid), 64'd0);
      check_eq("R8 done after limit fault", 64'(done), 64'd1);
      check_eq("R5 fault flag", 64'(fault), 64'd1);
      check_eq("R5 fault code is segment selector", 64'(fault_code), 64'(sel));
    end else begin
      for (int k = 0; k < (f[1] ? 1 : 2); k++) begin
        logic [31:0] a_exp;
        logic [1:0]  s_exp;
        logic [63:0] dat;
        a_exp = base + 32'(off) + ((k == 0) ? 32'd0 : ((f == 2'b00) ? 32'd2 : 32'd4));
        s_exp = (k == 0) ? ((f == 2'b00) ? 2'd1 : ((f == 2'b01) ? 2'd2 : 2'd3)) : 2'd1;
        check_eq("R7 request raised", 64'(mem_req_valid), 64'd1);
        check_eq({fmt_tag(f), " read address"}, 64'(mem_addr), 64'(a_exp));
        check_eq({fmt_tag(f), " read size"}, 64'(mem_size), 64'(s_exp));
        for (int w = 0; w < int'($urandom_range(0, 2)); w++) begin
          @(negedge clk);
          check_eq("R7 request held", 64'(mem_req_valid), 64'd1);
          check_eq("R7 address stable", 64'(mem_addr), 64'(a_exp));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int w = 0; w < int'($urandom_range(0, 2)); w++) begin
          check_eq("R7 nothing raised while waiting", 64'(mem_req_valid), 64'd0);
          @(negedge clk);
        end
        dat = {$urandom, $urandom};
        if (k == 1 && null_mode == 1) dat[15:2] = '0;
        if (k == 0) d0 = dat; else d1 = dat;
        mem_rsp_valid = 1'b1; mem_rdata = dat;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rdata = {$urandom, $urandom};
      end
      sp_exp = (f == 2'b00) ? (d0 & 64'hFFFF) : ((f == 2'b01) ? (d0 & 64'hFFFF_FFFF) : d0);
      ss_exp = f[1] ? {14'd0, l} : d1[15:0];
      is_null = !f[1] && !lm && (ss_exp[15:2] == 14'd0);
      check_eq("R8 done after last response", 64'(done), 64'd1);
      check_eq("R6 fault from selector check", 64'(fault), 64'(is_null));
      if (is_null) begin
        check_eq("R6 fault code is fetched selector", 64'(fault_code), 64'(ss_exp));
      end else begin
        check_eq({fmt_tag(f), " new pointer"}, new_sp, sp_exp);
        check_eq({fmt_tag(f), " new selector"}, 64'(new_ss), 64'(ss_exp));
      end
    end
    @(negedge clk);
    check_eq("R8 done is one cycle", 64'(done), 64'd0);
    check_eq("R1 ready again", 64'(req_ready), 64'd1);
    if (!exp_fault && !is_null) check_eq("R8 pointer held", new_sp, sp_exp);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nchk++; nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R9 reset ready", 64'(req_ready), 64'd1);
    check_eq("R9 reset request", 64'(mem_req_valid), 64'd0);
    check_eq("R9 reset done", 64'(done), 64'd0);
    check_eq("R9 reset fault", 64'(fault), 64'd0);
    check_eq("R9 reset selector", 64'(new_ss), 64'd0);
    check_eq("R9 reset pointer", new_sp, 64'd0);
    repeat (3) begin
      @(negedge clk);
      check_eq("R1 idle raises no request", 64'(mem_req_valid), 64'd0);
    end
    // boundary: exact fit and one short, every format and level
    for (int fi = 0; fi < 4; fi++) begin
      for (int li = 0; li < 4; li++) begin
        logic [1:0] f = 2'(fi);
        logic [1:0] l = 2'(li);
        longint e = exp_off(f, l) + exp_margin(f);
        run_txn(32'h0001_0000 + 32'(li * 256), 32'(e), f, l, 1'b1, 16'h0048, 0);
        run_txn(32'h0002_0000, 32'(e - 1), f, l, 1'b0, 16'h1234, 0);
      end
    end
    // null selector, with and without long mode
    run_txn(32'h0000_4000, 32'h67, 2'b01, 2'd2, 1'b0, 16'h0028, 1);
    run_txn(32'h0000_4000, 32'h67, 2'b00, 2'd1, 1'b0, 16'h0028, 1);
    run_txn(32'h0000_4000, 32'h67, 2'b01, 2'd2, 1'b1, 16'h0028, 1);
    // 64-bit format outside long mode: selector synthesized, no check
    run_txn(32'h0000_8000, 32'h67, 2'b10, 2'd0, 1'b0, 16'h0030, 0);
    // address wrap
    run_txn(32'hFFFF_FFFE, 32'hFFFF, 2'b01, 2'd3, 1'b0, 16'h0040, 0);
    run_txn(32'hFFFF_FFF0, 32'hFFFF, 2'b11, 2'd2, 1'b1, 16'h0040, 0);
    // random mix around the limit boundary
    for (int n = 0; n < 400; n++) begin
      logic [1:0] f = 2'($urandom_range(0, 3));
      logic [1:0] l = 2'($urandom_range(0, 3));
      longint e = exp_off(f, l) + exp_margin(f);
      longint lim = ($urandom_range(0, 7) == 0) ? longint'($urandom)
                                                : e + longint'($urandom_range(0, 3)) - 2;
      run_txn($urandom, 32'(lim), f, l, 1'($urandom_range(0, 1)),
              16'($urandom), int'($urandom_range(0, 3) == 0));
    end
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule